// File: doc/BRIEF.md
# MII Management Frame Controller

This block carries management transactions from a host to an Ethernet PHY over the two-wire MDC/MDIO interface. Software writes one 32-bit command word. That word already holds the start pattern, opcode, PHY address, register address, turnaround and write data. The controller first sends a run of preamble ones. It then shifts the command out MSB first. It generates MDC from the system clock, using a divisor that software programs into a speed register.

On a read, the controller releases MDIO during the turnaround and captures the 16 bits the PHY returns. At the end of the frame those bits replace the low half of the data register. Every finished frame raises a completion event, which software clears by writing a one to the event bit. Frames start only while MII mode is enabled and the divisor is non-zero. A busy flag covers the whole frame, and command writes made while it is set are dropped.

Top module: `mii_mgmt`

## Requirements
- R1: After reset, mdc_o and mdio_oe_o are low, mdio_o is high, busy_o and evt_o are low, and data_o is zero.
- R2: A frame on mdio_o is PRE_BITS ones followed by command bits 31 down to 0. The first bit appears the cycle after the accepted write. Each later bit appears at a falling MDC edge, and mdio_o changes at no other time during a frame.
- R3: The MDC divisor is bits [6:1] of the word written with spd_we_i. Each MDC half period lasts that many clock cycles, using the value held when the frame started. MDC is low when no frame is in flight.
- R4: A command write while the divisor is zero starts no frame.
- R5: A command write while mii_mode_i is low starts no frame.
- R6: busy_o is high from the cycle after an accepted write until the falling MDC edge that ends the last bit. A command write during that time changes neither data_o nor the frame.
- R7: A command whose bits [29:28] are 10 is a read. mdio_oe_o drops at the second turnaround bit (command bit 16) and stays low to the end of the frame.
- R8: On a read, mdio_i is sampled at each of the 16 rising MDC edges of the data field, MSB first. At completion the samples replace data_o[15:0], and data_o[31:16] keep the command bits.
- R9: For any other opcode, mdio_oe_o stays high for the whole frame and data_o keeps the written command word.
- R10: Completion sets evt_o. evt_o is cleared by an event-clear write with bit 23 set, and the other bits of that write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mii_mode_i | input | 1 | MII mode enable from receive control |
| cmd_we_i | input | 1 | Write strobe for the data register |
| cmd_wdata_i | input | 32 | Command word |
| spd_we_i | input | 1 | Write strobe for the speed register |
| spd_wdata_i | input | 32 | Speed word, divisor in [6:1] |
| evt_clr_i | input | 1 | Write strobe for the event register |
| evt_wdata_i | input | 32 | Write-one-to-clear word, bit 23 is the completion event |
| mdio_i | input | 1 | MDIO input from the pad |
| data_o | output | 32 | Data register contents |
| evt_o | output | 1 | Completion event |
| busy_o | output | 1 | Frame in flight |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The bench builds the block with the default 6-bit divisor field and a 32-bit preamble. It runs frames at divisors 1 and 3, so both the tightest MDC timing and a multi-cycle half period are compared against the reference model. A divisor of 1 makes each MDC edge fall on consecutive clocks, which exposes off-by-one errors in the bit counter and the turnaround release. A divisor of 3 checks that the captured divisor, not the live register, sets the frame's pace.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int CMD_W   = 32;
  localparam int DATA_W  = 16;
  localparam int EVT_BIT = 23;
  localparam int SPD_LSB = 1;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic is_read(input logic [CMD_W-1:0] c);
    return c[OP_HI:OP_LO] == OP_READ;
  endfunction
endpackage

// File: rtl/mii_mgmt_clkdiv.sv
module mii_mgmt_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             mdc_q, tick;

  assign tick   = run_i && (cnt_q == div_q - DIV_W'(1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (start_i) begin
      div_q <= div_i;  // divisor frozen for the whole frame
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else if (run_i) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  a_r3_mdc_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q);
  a_r3_mdc_holds_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick && !start_i) |=> $stable(mdc_q));
endmodule

// File: rtl/mii_mgmt_shift.sv
module mii_mgmt_shift
  import mii_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int N       = PRE_BITS + CMD_W;
  localparam int IDX_W   = $clog2(N + 1);
  localparam int TA2_IDX = PRE_BITS + CMD_W - DATA_W - 1;
  localparam int DAT_IDX = TA2_IDX + 1;
  localparam int LAST    = N - 1;

  logic [IDX_W-1:0]  idx_q, nidx;
  logic [CMD_W-1:0]  sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              busy_q, mdo_q, oe_q, rd_q;

  assign nidx   = idx_q + IDX_W'(1);
  assign done_o = busy_q && fall_i && (idx_q == IDX_W'(LAST));
  assign busy_o = busy_q;
  assign mdio_o = mdo_q;
  assign oe_o   = oe_q;
  assign rd_o   = rd_q;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      rd_q   <= is_read(cmd_i);
      rx_q   <= '0;
      oe_q   <= 1'b1;
      if (PRE_BITS > 0) begin
        mdo_q <= 1'b1;
        sh_q  <= cmd_i;
      end else begin
        mdo_q <= cmd_i[CMD_W-1];
        sh_q  <= cmd_i << 1;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      mdo_q  <= 1'b1;
    end else if (busy_q && fall_i) begin
      idx_q <= nidx;
      if (nidx >= IDX_W'(PRE_BITS)) begin
        mdo_q <= sh_q[CMD_W-1];
        sh_q  <= sh_q << 1;
      end else begin
        mdo_q <= 1'b1;
      end
      oe_q <= !(rd_q && (nidx >= IDX_W'(TA2_IDX)));
    end else if (busy_q && rise_i && rd_q && (idx_q >= IDX_W'(DAT_IDX))) begin
      rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  a_r2_mdio_changes_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> $stable(mdo_q));
  a_r7_released_in_read_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_q && (idx_q > IDX_W'(TA2_IDX))) |-> !oe_q);
  a_r9_write_keeps_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_q) |-> oe_q);
endmodule

// File: rtl/mii_mgmt.sv
module mii_mgmt
  import mii_mgmt_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int PRE_BITS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mii_mode_i,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  input  logic        spd_we_i,
  input  logic [31:0] spd_wdata_i,
  input  logic        evt_clr_i,
  input  logic [31:0] evt_wdata_i,
  input  logic        mdio_i,
  output logic [31:0] data_o,
  output logic        evt_o,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int SPD_MSB = SPD_LSB + DIV_W - 1;

  logic [DIV_W-1:0]  div_q;
  logic [CMD_W-1:0]  data_q;
  logic              evt_q, start, busy, done, rd, rise, fall;
  logic [DATA_W-1:0] rx;
  logic              unused_bits;

  assign unused_bits = ^{spd_wdata_i[31:SPD_MSB+1], spd_wdata_i[SPD_LSB-1:0],
                         evt_wdata_i[31:EVT_BIT+1], evt_wdata_i[EVT_BIT-1:0]};

  assign start = cmd_we_i && mii_mode_i && !busy && (div_q != '0);

  mii_mgmt_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .start_i(start), .run_i(busy), .div_i(div_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mii_mgmt_shift #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd_wdata_i), .rise_i(rise),
    .fall_i(fall), .mdio_i, .busy_o(busy), .mdio_o, .oe_o(mdio_oe_o),
    .done_o(done), .rd_o(rd), .rx_o(rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      data_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (spd_we_i) div_q <= spd_wdata_i[SPD_MSB:SPD_LSB];
      if (start) data_q <= cmd_wdata_i;
      else if (done && rd) data_q[DATA_W-1:0] <= rx;
      if (done) evt_q <= 1'b1;  // set wins over a same-cycle clear
      else if (evt_clr_i && evt_wdata_i[EVT_BIT]) evt_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign evt_o  = evt_q;
  assign busy_o = busy;

  a_r4_no_start_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cmd_we_i && (div_q == '0)) |=> !busy);
  a_r5_no_start_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cmd_we_i && !mii_mode_i) |=> !busy);
  a_r6_busy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we_i && !done) |=> $stable(data_q));
  a_r10_done_sets_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> evt_q);
  a_r10_event_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && !(evt_clr_i && evt_wdata_i[EVT_BIT])) |=> $stable(evt_q));
endmodule

// File: tb/tb_mii_mgmt.sv
`timescale 1ns/1ps
module tb_mii_mgmt;
  localparam int PRE = 32;
  localparam int N   = PRE + 32;

  logic clk = 0, rst_n = 0;
  logic mii_mode = 0, cmd_we = 0, spd_we = 0, evt_clr = 0, mdio_i = 1;
  logic [31:0] cmd_wdata = 0, spd_wdata = 0, evt_wdata = 0;
  logic [31:0] data_o;
  logic evt_o, busy_o, mdc_o, mdio_o, mdio_oe_o;

  always #2 clk = ~clk;

  mii_mgmt #(.DIV_W(6), .PRE_BITS(PRE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mii_mode_i(mii_mode), .cmd_we_i(cmd_we),
    .cmd_wdata_i(cmd_wdata), .spd_we_i(spd_we), .spd_wdata_i(spd_wdata),
    .evt_clr_i(evt_clr), .evt_wdata_i(evt_wdata), .mdio_i(mdio_i),
    .data_o(data_o), .evt_o(evt_o), .busy_o(busy_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  int vec = 0, errs = 0;
  logic [15:0] phy16 = 16'h0000;

  // behavioural reference
  bit m_busy = 0, m_mdc = 0, m_oe = 0, m_mdo = 1, m_evt = 0, m_rd = 0;
  int m_cnt = 0, m_div = 0, m_field = 0, m_k = 0;
  logic [31:0] m_data = 0;
  logic [15:0] m_rx = 0;
  bit q_bits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_mdc = 0; m_oe = 0; m_mdo = 1; m_evt = 0; m_data = 0; m_field = 0;
    end else begin
      bit set_ev;
      set_ev = 0;
      if (m_busy) begin
        if (m_cnt == m_div - 1) begin
          m_cnt = 0;
          if (!m_mdc) begin
            m_mdc = 1;
            if (m_rd && m_k >= PRE + 16) m_rx = {m_rx[14:0], mdio_i};
          end else begin
            m_mdc = 0;
            if (m_k == N - 1) begin
              m_busy = 0; set_ev = 1; m_oe = 0; m_mdo = 1;
              if (m_rd) m_data[15:0] = m_rx;
            end else begin
              m_k++;
              m_mdo = q_bits.pop_front();
              m_oe = !(m_rd && m_k >= PRE + 15);
            end
          end
        end else m_cnt++;
      end else if (cmd_we && mii_mode && m_field != 0) begin
        m_busy = 1; m_data = cmd_wdata; m_div = m_field; m_cnt = 0; m_mdc = 0;
        m_k = 0; m_oe = 1; m_rd = (cmd_wdata[29:28] == 2'b10); m_rx = 0;
        q_bits.delete();
        for (int i = 0; i < PRE; i++) q_bits.push_back(1'b1);
        for (int i = 31; i >= 0; i--) q_bits.push_back(cmd_wdata[i]);
        m_mdo = q_bits.pop_front();
      end
      if (spd_we) m_field = int'(spd_wdata[6:1]);
      if (set_ev) m_evt = 1;
      else if (evt_clr && evt_wdata[23]) m_evt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare, then PHY model drives mdio_i
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 mdc", {31'b0, mdc_o}, {31'b0, m_mdc});
      chk("R2 mdio", {31'b0, mdio_o}, {31'b0, m_mdo});
      chk("R7 oe", {31'b0, mdio_oe_o}, {31'b0, m_oe});
      chk("R6 busy", {31'b0, busy_o}, {31'b0, m_busy});
      chk("R10 evt", {31'b0, evt_o}, {31'b0, m_evt});
      chk("R8 data", data_o, m_data);
    end
    if (m_busy && m_rd && m_k >= PRE + 16) mdio_i = phy16[15 - (m_k - PRE - 16)];
    else if (m_busy && m_rd && m_k == PRE + 15) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  end

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic set_div(input int f);
    @(negedge clk); spd_we = 1; spd_wdata = 32'(f) << 1;
    @(negedge clk); spd_we = 0;
  endtask
  task automatic clear_evt(input logic [31:0] w);
    @(negedge clk); evt_clr = 1; evt_wdata = w;
    @(negedge clk); evt_clr = 0;
  endtask
  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++; vec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] wr_cmd, rd_cmd, rd2;
    wr_cmd = 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'hBEEF;
    rd_cmd = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18);
    rd2    = 32'h6002_0000 | (32'd31 << 23) | (32'd31 << 18);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mdc", {31'b0, mdc_o}, 0);
    chk("R1 oe", {31'b0, mdio_oe_o}, 0);
    chk("R1 mdio", {31'b0, mdio_o}, 1);
    chk("R1 busy", {31'b0, busy_o}, 0);
    chk("R1 evt", {31'b0, evt_o}, 0);
    chk("R1 data", data_o, 0);
    rst_n = 1;
    mii_mode = 1;
    // R4 divisor zero
    send_cmd(wr_cmd);
    @(negedge clk);
    chk("R4 no start", {31'b0, busy_o}, 0);
    // R5 mode off
    set_div(2);
    mii_mode = 0;
    send_cmd(wr_cmd);
    chk("R5 no start", {31'b0, busy_o}, 0);
    mii_mode = 1;
    // write frame at divisor 1, R9
    set_div(1);
    send_cmd(wr_cmd);
    chk("R6 busy after write", {31'b0, busy_o}, 1);
    wait_idle();
    @(negedge clk);
    chk("R9 data kept", data_o, wr_cmd);
    chk("R10 evt set", {31'b0, evt_o}, 1);
    clear_evt(32'hFF7F_FFFF);
    chk("R10 other bits no clear", {31'b0, evt_o}, 1);
    clear_evt(32'h0080_0000);
    chk("R10 cleared", {31'b0, evt_o}, 0);
    // read frame at divisor 3, with a dropped write and a divisor change mid-frame (R3, R6)
    set_div(3);
    phy16 = 16'hA5C3;
    send_cmd(rd_cmd);
    repeat (20) @(negedge clk);
    send_cmd(wr_cmd);
    chk("R6 write dropped", data_o, rd_cmd);
    set_div(5);
    wait_idle();
    @(negedge clk);
    chk("R8 read data", data_o, {rd_cmd[31:16], 16'hA5C3});
    // read frame at divisor 1, boundary data
    set_div(1);
    phy16 = 16'h8001;
    send_cmd(rd2);
    wait_idle();
    @(negedge clk);
    chk("R8 read edge bits", data_o, {rd2[31:16], 16'h8001});
    chk("R7 oe after read", {31'b0, mdio_oe_o}, 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule